// File: doc/BRIEF.md
# SD card SPI-mode data block writer

This block carries the data phase of a card write in SPI mode, once the write command has been issued elsewhere. It pulls payload bytes from a valid/ready stream and frames each block: an idle filler byte, a start token chosen by the transfer mode, the payload, and a CRC16 computed on the fly. It then polls for the card's data response and waits out the busy period that follows. In multi-block mode it closes the transfer with a stop token and a second busy wait.

The block talks to a byte-exchange engine below it. It holds a request with the byte to send until the engine pulses a completion that returns the byte received from the card. At the end of the transfer it raises a one-cycle done pulse and reports one of three outcomes: ok, rejected (a CRC or write error, or no response), or busy timeout. Chip select and command issue belong to other logic.

Top module: `sd_spi_block_writer`

## Requirements
- R1: Every block begins with a 0xFF byte and then a start token: 0xFE when `multi` is 0 and 0xFC when `multi` is 1. The number of blocks is `blk_last`+1, sampled together with `multi` when `start` is seen while idle.
- R2: Payload bytes are sent in stream order, BLOCK_BYTES per block. A byte is consumed (`pay_ready` high, only while `pay_valid` is high) in the cycle its exchange completes.
- R3: After the payload of a block come two bytes of CRC16-CCITT over that payload (polynomial 0x1021, initial value 0, bits fed MSB first), high byte first.
- R4: After the CRC the block sends 0xFF up to 8 times. The first received byte with bit 4 clear is the data response, and a low 5-bit value of 0x05 means accepted.
- R5: A response whose low 5 bits are not 0x05, or 8 polls with no response, ends the transfer with status 1 (rejected). No further byte is sent, and no stop token either.
- R6: After acceptance the block polls by sending 0xFF. The first byte received is ignored, and any later 0xFF ends the busy wait.
- R7: A busy wait that has not ended after BUSY_LIMIT polls ends the transfer with status 2 (timeout). A wait that ends on poll number BUSY_LIMIT succeeds.
- R8: When all blocks succeed with `multi` at 1, the block sends 0xFF, then 0xFD, then runs the busy wait of R6/R7. Success gives status 0 (ok). With `multi` at 0, success after the last block gives status 0 directly.
- R9: `done` is high for exactly one cycle per transfer. `status` holds the outcome (0 ok, 1 rejected, 2 timeout, never 3) from that cycle until the next outcome. After reset, `done` and `xfer_req` are low and `status` is 0.
- R10: Once `xfer_req` is raised it stays high with `xfer_tx` unchanged until `xfer_done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| multi | input | 1 | 1 = multi-block write, 0 = single-block tokens |
| blk_last | input | BLK_CNT_W | Number of blocks minus one |
| pay_valid | input | 1 | Payload byte available |
| pay_data | input | 8 | Payload byte |
| pay_ready | output | 1 | Payload byte consumed this cycle |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to send to the card |
| xfer_done | input | 1 | Exchange complete (one-cycle pulse) |
| xfer_rx | input | 8 | Byte received in the completed exchange |
| done | output | 1 | Transfer finished (one-cycle pulse) |
| status | output | 2 | Outcome: 0 ok, 1 rejected, 2 timeout |

## Verification
The hard cases depend on which byte the card returns at one exact position in a long exchange. Examples are a response that arrives only on the eighth poll, a busy release on the last allowed poll, and a rejection in the middle block of a multi-block run. Before each transfer the bench builds a reply table indexed by exchange number together with the expected outgoing frame. The engine model answers from that table, so each of these positions is placed on purpose. Engine latency and payload gaps vary from byte to byte, so the same frames also arrive under different stalls.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [7:0] TOK_SINGLE  = 8'hFE;
    localparam logic [7:0] TOK_MULTI   = 8'hFC;
    localparam logic [7:0] TOK_STOP    = 8'hFD;
    localparam logic [4:0] RESP_ACCEPT = 5'h05;
    localparam int         RESP_POLLS  = 8;

    typedef enum logic [1:0] {
        WR_OK      = 2'd0,
        WR_REJECT  = 2'd1,
        WR_TIMEOUT = 2'd2
    } wr_status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FILL,
        S_TOKEN,
        S_DATA,
        S_CRC_HI,
        S_CRC_LO,
        S_RESP,
        S_BUSY,
        S_STOP_FILL,
        S_STOP_TOK,
        S_STOP_BUSY
    } wr_state_e;

    // one payload byte into a CCITT CRC, MSB first
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc, input logic [7:0] d);
        logic [15:0] c;
        logic        fb;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdw_crc16.sv
module sdw_crc16 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    import sdw_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc16_byte(crc, data);
        end
    end
endmodule

// File: rtl/sdw_poll_counter.sv
module sdw_poll_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic first,
    output logic last
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST_IDX = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign first = (cnt == '0);
    assign last  = (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step && !last) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sd_spi_block_writer.sv
module sd_spi_block_writer #(
    parameter int BLOCK_BYTES = 512,
    parameter int BLK_CNT_W   = 8,
    parameter int BUSY_LIMIT  = 3000000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 multi,
    input  logic [BLK_CNT_W-1:0] blk_last,
    input  logic                 pay_valid,
    input  logic [7:0]           pay_data,
    output logic                 pay_ready,
    output logic                 xfer_req,
    output logic [7:0]           xfer_tx,
    input  logic                 xfer_done,
    input  logic [7:0]           xfer_rx,
    output logic                 done,
    output logic [1:0]           status
);
    import sdw_pkg::*;

    localparam int BYTE_W = (BLOCK_BYTES > 2) ? $clog2(BLOCK_BYTES) : 1;
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(BLOCK_BYTES - 1);

    wr_state_e            state_q, state_d;
    logic [BYTE_W-1:0]    byte_q, byte_d;
    logic [BLK_CNT_W-1:0] left_q, left_d;
    logic                 multi_q, multi_d;
    wr_status_e           status_q, fin_status;
    logic                 done_q, finish;

    logic [15:0] crc;
    logic        resp_first, resp_last;
    logic        busy_first, busy_last;
    logic        in_busy, busy_end, busy_tmo;

    assign in_busy   = (state_q == S_BUSY) || (state_q == S_STOP_BUSY);
    assign pay_ready = (state_q == S_DATA) && xfer_done;

    sdw_crc16 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q == S_FILL),
        .en    (pay_ready && pay_valid),
        .data  (pay_data),
        .crc   (crc)
    );

    sdw_poll_counter #(.LIMIT(RESP_POLLS)) u_resp_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q != S_RESP),
        .step  ((state_q == S_RESP) && xfer_done),
        .first (resp_first),
        .last  (resp_last)
    );

    sdw_poll_counter #(.LIMIT(BUSY_LIMIT)) u_busy_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (!in_busy),
        .step  (in_busy && xfer_done),
        .first (busy_first),
        .last  (busy_last)
    );

    assign busy_end = xfer_done && !busy_first && (xfer_rx == FILL_BYTE);
    assign busy_tmo = xfer_done && !busy_end && busy_last;

    // byte exchange request and outgoing byte
    always_comb begin
        xfer_req = 1'b1;
        xfer_tx  = FILL_BYTE;
        unique case (state_q)
            S_IDLE:     xfer_req = 1'b0;
            S_TOKEN:    xfer_tx  = multi_q ? TOK_MULTI : TOK_SINGLE;
            S_DATA: begin
                xfer_req = pay_valid;
                xfer_tx  = pay_data;
            end
            S_CRC_HI:   xfer_tx  = crc[15:8];
            S_CRC_LO:   xfer_tx  = crc[7:0];
            S_STOP_TOK: xfer_tx  = TOK_STOP;
            default:    xfer_tx  = FILL_BYTE;
        endcase
    end

    always_comb begin
        state_d    = state_q;
        byte_d     = byte_q;
        left_d     = left_q;
        multi_d    = multi_q;
        finish     = 1'b0;
        fin_status = WR_OK;
        unique case (state_q)
            S_IDLE: if (start) begin
                state_d = S_FILL;
                multi_d = multi;
                left_d  = blk_last;
                byte_d  = '0;
            end
            S_FILL:  if (xfer_done) state_d = S_TOKEN;
            S_TOKEN: if (xfer_done) state_d = S_DATA;
            S_DATA: if (xfer_done) begin
                if (byte_q == LAST_BYTE) begin
                    byte_d  = '0;
                    state_d = S_CRC_HI;
                end else begin
                    byte_d  = byte_q + 1'b1;
                end
            end
            S_CRC_HI: if (xfer_done) state_d = S_CRC_LO;
            S_CRC_LO: if (xfer_done) state_d = S_RESP;
            S_RESP: if (xfer_done) begin
                if (!xfer_rx[4]) begin
                    if (xfer_rx[4:0] == RESP_ACCEPT) begin
                        state_d = S_BUSY;
                    end else begin
                        finish     = 1'b1;
                        fin_status = WR_REJECT;
                    end
                end else if (resp_last) begin
                    finish     = 1'b1;
                    fin_status = WR_REJECT;
                end
            end
            S_BUSY: begin
                if (busy_end) begin
                    if (left_q != '0) begin
                        left_d  = left_q - 1'b1;
                        state_d = S_FILL;
                    end else if (multi_q) begin
                        state_d = S_STOP_FILL;
                    end else begin
                        finish = 1'b1;
                    end
                end else if (busy_tmo) begin
                    finish     = 1'b1;
                    fin_status = WR_TIMEOUT;
                end
            end
            S_STOP_FILL: if (xfer_done) state_d = S_STOP_TOK;
            S_STOP_TOK:  if (xfer_done) state_d = S_STOP_BUSY;
            S_STOP_BUSY: begin
                if (busy_end) begin
                    finish = 1'b1;
                end else if (busy_tmo) begin
                    finish     = 1'b1;
                    fin_status = WR_TIMEOUT;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (finish) state_d = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            byte_q   <= '0;
            left_q   <= '0;
            multi_q  <= 1'b0;
            status_q <= WR_OK;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            left_q  <= left_d;
            multi_q <= multi_d;
            done_q  <= finish;
            if (finish) status_q <= fin_status;
        end
    end

    assign done   = done_q;
    assign status = status_q;

endmodule

// File: rtl/sdw_checker.sv
module sdw_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       pay_valid,
    input logic       pay_ready,
    input logic       xfer_req,
    input logic [7:0] xfer_tx,
    input logic       xfer_done,
    input logic       done,
    input logic [1:0] status
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    status_code_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (status != 2'd3));

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(status));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_tx)));

    // R2
    ready_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pay_ready |-> (pay_valid && xfer_done));

    // R5
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !xfer_req);
endmodule

bind sd_spi_block_writer sdw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pay_valid (pay_valid),
    .pay_ready (pay_ready),
    .xfer_req  (xfer_req),
    .xfer_tx   (xfer_tx),
    .xfer_done (xfer_done),
    .done      (done),
    .status    (status)
);

// File: tb/sim_sd_spi_block_writer.sv
module sim_sd_spi_block_writer;
    localparam int B   = 4;
    localparam int CW  = 2;
    localparam int LIM = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          multi = 1'b0;
    logic [CW-1:0] blk_last = '0;
    logic          pay_valid = 1'b0;
    logic [7:0]    pay_data = 8'h00;
    logic          pay_ready;
    logic          xfer_req;
    logic [7:0]    xfer_tx;
    logic          xfer_done = 1'b0;
    logic [7:0]    xfer_rx = 8'hFF;
    logic          done;
    logic [1:0]    status;

    sd_spi_block_writer #(.BLOCK_BYTES(B), .BLK_CNT_W(CW), .BUSY_LIMIT(LIM)) u0 (
        .clk(clk), .rst(rst), .start(start), .multi(multi), .blk_last(blk_last),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
        .done(done), .status(status)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [7:0] e_tx [0:255];
    logic [7:0] e_rx [0:255];
    logic [7:0] log_tx [0:255];
    logic [7:0] pay [0:63];
    int e_n, pay_n, e_status;
    int rd [0:3];
    int rc [0:3];
    int bz [0:3];
    int sz;

    int  k = 0, pidx = 0, gap = 0, cd = 0, hold_err = 0;
    bit  act = 0, running = 0, fire_q = 0;
    logic [7:0] cap;

    task automatic chk(input bit ok, input string req, input string what, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    function automatic logic [15:0] ccitt(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic push(input logic [7:0] t, input logic [7:0] r);
        e_tx[e_n] = t;
        e_rx[e_n] = r;
        e_n++;
    endtask

    task automatic busy_script(input int z, output bit ok);
        logic [7:0] r;
        ok = 0;
        for (int p = 0; p < LIM; p++) begin
            r = (p == 0) ? 8'hFF : ((p <= z) ? 8'h00 : 8'hFF);
            push(8'hFF, r);
            if (p > 0 && r == 8'hFF) begin
                ok = 1;
                return;
            end
        end
    endtask

    task automatic build(input bit m, input int nb, input int seed);
        bit abort, ok;
        logic [15:0] c;
        logic [7:0] d;
        e_n = 0; pay_n = 0; e_status = 0; abort = 0;
        for (int b = 0; b < nb && !abort; b++) begin
            push(8'hFF, 8'h5A);
            push(m ? 8'hFC : 8'hFE, 8'h5A);
            c = 16'h0000;
            for (int i = 0; i < B; i++) begin
                d = 8'((seed * 37 + b * 11 + i * 73 + 1) & 255);
                pay[pay_n] = d; pay_n++;
                push(d, 8'h5A);
                c = ccitt(c, d);
            end
            push(c[15:8], 8'h5A);
            push(c[7:0], 8'h5A);
            for (int p = 0; p < 8; p++) begin
                if (p < rd[b]) push(8'hFF, 8'hFF);
                else begin
                    push(8'hFF, 8'(rc[b]));
                    break;
                end
            end
            if (rd[b] >= 8 || (rc[b] & 8'h1F) != 8'h05) begin
                e_status = 1; abort = 1;
            end else begin
                busy_script(bz[b], ok);
                if (!ok) begin
                    e_status = 2; abort = 1;
                end
            end
        end
        if (!abort && m) begin
            push(8'hFF, 8'h5A);
            push(8'hFD, 8'h5A);
            busy_script(sz, ok);
            if (!ok) e_status = 2;
        end
    endtask

    always @(posedge clk) fire_q <= pay_valid && pay_ready;

    // byte engine and payload source, all driven on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (fire_q) begin
                pidx++;
                pay_valid = 1'b0;
                gap = pidx % 3;
            end
            if (xfer_done) begin
                xfer_done = 1'b0;
                k++;
                act = 0;
            end else if (act) begin
                if (!xfer_req || xfer_tx != cap) hold_err++;
                if (cd == 0) begin
                    xfer_done = 1'b1;
                    xfer_rx = (k < 256) ? e_rx[k] : 8'hFF;
                end else cd--;
            end else if (xfer_req) begin
                if (k < 256) log_tx[k] = xfer_tx;
                cap = xfer_tx;
                act = 1;
                cd = k % 3;
            end
            if (running && !pay_valid && pidx < pay_n) begin
                if (gap > 0) gap--;
                else begin
                    pay_valid = 1'b1;
                    pay_data = pay[pidx];
                end
            end
        end
    end

    task automatic run(input bit m, input int nb, input int seed, input string tag);
        int cnt, bad;
        logic [1:0] st;
        build(m, nb, seed);
        k = 0; pidx = 0; gap = 0; hold_err = 0; running = 1;
        @(negedge clk);
        multi = m; blk_last = CW'(nb - 1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        chk(done, tag, "done seen", done, 1);
        st = status;
        @(negedge clk);
        chk(!done && !xfer_req, "R9", "done single cycle, bus quiet", {done, xfer_req}, 0);
        chk(status == st, "R9", "status held", status, st);
        chk(int'(st) == e_status, tag, "status", st, e_status);
        chk(k == e_n, tag, "exchange count", k, e_n);
        bad = -1;
        for (int i = 0; i < e_n && i < k; i++)
            if (bad < 0 && log_tx[i] !== e_tx[i]) bad = i;
        chk(bad < 0, tag, "frame byte", (bad < 0) ? 0 : log_tx[bad], (bad < 0) ? 0 : e_tx[bad]);
        chk(pidx == pay_n, "R2", "payload bytes consumed", pidx, pay_n);
        chk(hold_err == 0, "R10", "request held stable", hold_err, 0);
        running = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic scen(input int r, input int code, input int z);
        for (int b = 0; b < 4; b++) begin
            rd[b] = r; rc[b] = code; bz[b] = z;
        end
        sz = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !xfer_req && !pay_ready, "R9", "reset outputs idle", {done, xfer_req, pay_ready}, 0);
        chk(status == 2'd0, "R9", "reset status", status, 0);

        // sweep of modes, block counts and reply timing: R1 R2 R3 R4 R6 R8
        for (int m = 0; m < 2; m++) begin
            for (int nb = 1; nb <= 3; nb++) begin
                for (int b = 0; b < 4; b++) begin
                    rd[b] = (b + nb + m) % 4;
                    rc[b] = (b % 2) ? 8'hE5 : 8'h05;
                    bz[b] = (b + nb) % 3;
                end
                sz = nb % 3;
                run(m[0], nb, nb * 5 + m, "R1 R3 R8");
            end
        end

        scen(7, 8'h25, 1); run(0, 1, 9, "R4 last poll");
        scen(8, 8'h05, 1); run(0, 1, 10, "R5 no response");
        scen(0, 8'h05, 0); rc[1] = 8'h2B; run(1, 3, 11, "R5 crc error mid block");
        scen(2, 8'hED, 0); run(0, 1, 12, "R5 write error");
        scen(0, 8'h05, 0); run(0, 1, 13, "R6 first poll ignored");
        scen(0, 8'h05, LIM - 2); run(0, 1, 14, "R7 release on last poll");
        scen(0, 8'h05, LIM - 1); run(0, 1, 15, "R7 busy timeout");
        scen(1, 8'h05, 0); sz = LIM - 1; run(1, 2, 16, "R7 R8 stop busy timeout");
        scen(1, 8'h05, 0); sz = LIM - 2; run(1, 1, 17, "R8 stop busy ok");
        scen(0, 8'h05, 1); run(0, 2, 18, "R1 single token per block");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule